// File: doc/BRIEF.md
# UART Start Bit Validator

This block sits at the front of a UART receiver. It takes the asynchronous receive line and a sample enable that pulses sixteen times per bit period. It decides whether a high-to-low transition is a real start bit. The line first passes through a synchroniser. A candidate begins when a low sample follows a run of high samples while the block is idle. The ticks of the candidate are numbered from 1, with the first low sample as tick 1.

Inside the candidate bit the line is sampled as two triplets: an early triplet at ticks 3, 5 and 7, and a mid-bit triplet at ticks 8, 9 and 10. Each triplet is judged by majority vote. When all six samples are low, the start is clean. When both triplets hold a low majority but at least one is not unanimous, the start is accepted and flagged as noisy. When either triplet lacks a low majority, the candidate is dropped at tick 10.

An accepted start produces a one-clock confirm pulse at tick 16, which is the bit boundary. A downstream shifter counts ticks from that pulse and keeps the same mid-bit offsets for the data bits. The current tick index is also brought out for alignment.

Top module: `uart_start_validator`

## Requirements
- R1: While rst_ni is low, start_o and noise_o are 0 and phase_o is 0.
- R2: In idle, a candidate starts on a tick whose synchronised sample is 0 and whose three preceding tick samples were all 1. After that tick, phase_o reads 1. At every other time, samples on the line start nothing.
- R3: During a candidate, phase_o goes up by one on each tick, covering 1 to 15. It changes only on ticks. In idle it is 0.
- R4: Only the samples at ticks 3, 5, 7 (early triplet) and 8, 9, 10 (mid triplet) affect the outcome. The line value at every other tick is ignored.
- R5: If all six voted samples are 0, the start is accepted and noise_o stays 0.
- R6: If both triplets have at least two 0 samples and at least one triplet has exactly two, the start is accepted and noise_o is set to 1 at tick 10.
- R7: If either triplet has fewer than two 0 samples, the candidate is aborted at tick 10: phase_o returns to 0, start_o does not pulse, and noise_o stays 0.
- R8: An accepted start raises start_o for exactly one clock, in the clock after tick 16 is taken. At that point phase_o returns to 0.
- R9: noise_o is cleared on the tick that starts a new candidate and otherwise holds its value. It changes only in the clock after a tick.
- R10: After an abort, a new candidate needs three fresh 1 samples before the 0 sample. A 0 that follows only one or two 1 samples is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable, 16 pulses per bit period |
| rx_i | input | 1 | Asynchronous serial receive line |
| start_o | output | 1 | One-clock pulse: start bit accepted |
| noise_o | output | 1 | Last accepted start had a non-unanimous vote |
| phase_o | output | 4 | Tick index within the candidate start bit, 0 in idle |

## Verification
Several properties are checked on every cycle. start_o lasts one clock and follows a tick taken at phase 15. phase_o moves only on ticks, and only by one step up or back to 0. noise_o changes only after a tick, and it reads low once a new candidate has begun.

Other behaviour is shown only by the bench scenarios, because it depends on the line values at particular ticks. This covers the three-way outcome for each zero pattern, the ignored non-voting ticks, and rejection of a 0 that comes too soon after an abort.

// File: rtl/uart_sbv_pkg.sv
package uart_sbv_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CHECK = 1'b1
  } sbv_state_e;
endpackage

// File: rtl/sbv_sync.sv
module sbv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sbv_edge.sv
module sbv_edge #(
  parameter int RUN_ONES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  output logic fall_o
);
  logic [RUN_ONES-1:0] hist_q;

  // history starts low: a full run of ones is needed after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= '0;
    else if (tick_i) hist_q <= {hist_q[RUN_ONES-2:0], rx_i};
  end

  assign fall_o = tick_i && (&hist_q) && !rx_i;
endmodule

// File: rtl/sbv_vote.sv
module sbv_vote (
  input  logic [2:0] samp_i,
  output logic       ok_o,
  output logic       clean_o
);
  logic [1:0] zeros;

  always_comb begin
    zeros = 2'(!samp_i[0]) + 2'(!samp_i[1]) + 2'(!samp_i[2]);
    ok_o    = zeros >= 2'd2;
    clean_o = zeros == 2'd3;
  end
endmodule

// File: rtl/uart_start_validator.sv
module uart_start_validator
  import uart_sbv_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_ONES   = 3,
  localparam int PH_W       = $clog2(OVERSAMPLE)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            rx_i,
  output logic            start_o,
  output logic            noise_o,
  output logic [PH_W-1:0] phase_o
);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [PH_W-1:0] TA0  = PH_W'(MID - 5);
  localparam logic [PH_W-1:0] TA1  = PH_W'(MID - 3);
  localparam logic [PH_W-1:0] TA2  = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] TB0  = PH_W'(MID);
  localparam logic [PH_W-1:0] TB1  = PH_W'(MID + 1);
  localparam logic [PH_W-1:0] TB2  = PH_W'(MID + 2);
  localparam logic [PH_W-1:0] TEND = PH_W'(OVERSAMPLE - 1);

  sbv_state_e      state_q;
  logic [PH_W-1:0] phase_q, ph_nxt;
  logic [2:0]      grp_a_q, grp_b_q, grp_b_now;
  logic            rx_s, fall, a_ok, a_clean, b_ok, b_clean;
  logic            start_q, noise_q;

  sbv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rx_i), .q_o (rx_s)
  );

  sbv_edge #(.RUN_ONES(IDLE_ONES)) u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i), .rx_i (rx_s), .fall_o (fall)
  );

  always_comb begin
    ph_nxt    = phase_q + 1'b1;
    grp_b_now = grp_b_q;
    if (ph_nxt == TB2) grp_b_now[2] = rx_s;
  end

  sbv_vote u_vote_a (.samp_i (grp_a_q),   .ok_o (a_ok), .clean_o (a_clean));
  sbv_vote u_vote_b (.samp_i (grp_b_now), .ok_o (b_ok), .clean_o (b_clean));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      grp_a_q <= '1;
      grp_b_q <= '1;
      start_q <= 1'b0;
      noise_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (fall) begin
              state_q <= ST_CHECK;
              phase_q <= PH_W'(1);
              noise_q <= 1'b0;
              grp_a_q <= '1;
              grp_b_q <= '1;
            end
          end
          ST_CHECK: begin
            phase_q <= ph_nxt;
            if (ph_nxt == TA0) grp_a_q[0] <= rx_s;
            if (ph_nxt == TA1) grp_a_q[1] <= rx_s;
            if (ph_nxt == TA2) grp_a_q[2] <= rx_s;
            if (ph_nxt == TB0) grp_b_q[0] <= rx_s;
            if (ph_nxt == TB1) grp_b_q[1] <= rx_s;
            if (ph_nxt == TB2) begin
              grp_b_q[2] <= rx_s;
              if (!(a_ok && b_ok)) begin
                state_q <= ST_IDLE;
                phase_q <= '0;
              end else begin
                noise_q <= !(a_clean && b_clean);
              end
            end
            if (phase_q == TEND) begin
              start_q <= 1'b1;
              state_q <= ST_IDLE;
              phase_q <= '0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign start_o = start_q;
  assign noise_o = noise_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/uart_start_validator_chk.sv
module uart_start_validator_chk #(
  parameter int PH_W = 4,
  parameter int OVERSAMPLE = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            start_o,
  input logic            noise_o,
  input logic [PH_W-1:0] phase_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!start_o && !noise_o && phase_o == '0)); // R1

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R8

  AST_START_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && phase_o == PH_W'(OVERSAMPLE - 1) |=> start_o && phase_o == '0); // R8

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_o)); // R3

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && phase_o != '0 |=> (phase_o == $past(phase_o) + 1'b1) || phase_o == '0); // R3

  AST_NOISE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(noise_o)); // R9

  AST_NOISE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && phase_o == '0 |=> (phase_o != PH_W'(1) || !noise_o)); // R9
endmodule

bind uart_start_validator uart_start_validator_chk #(
  .PH_W(PH_W), .OVERSAMPLE(OVERSAMPLE)
) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
  .start_o (start_o), .noise_o (noise_o), .phase_o (phase_o)
);

// File: tb/uart_start_validator_tb.sv
module uart_start_validator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] div = '0;
  logic       tick;
  logic       start, noise;
  logic [3:0] phase;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;
  logic       last_noise = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) div <= div + 2'd1;
  assign tick = (div == 2'd3);

  uart_start_validator u_dut (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .rx_i (rx),
    .start_o (start), .noise_o (noise), .phase_o (phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // waits for the next tick to be taken, ends at the following falling edge
  task automatic take_tick();
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  task automatic lead_ones();
    rx = 1'b1;
    for (int i = 0; i < 4; i++) take_tick();
  endtask

  // pat[1] is tick 1 (must be 0)
  task automatic run_case(input string name, input logic [1:16] pat);
    int  za, zb;
    bit  ok, nz;
    za = int'(!pat[3]) + int'(!pat[5]) + int'(!pat[7]);
    zb = int'(!pat[8]) + int'(!pat[9]) + int'(!pat[10]);
    ok = (za >= 2) && (zb >= 2);
    nz = ok && !(za == 3 && zb == 3);
    lead_ones();
    chk({"R9 hold ", name}, noise, last_noise);
    rx = pat[1];
    for (int k = 1; k <= 16; k++) begin
      take_tick();
      if (k == 1) begin
        chk({"R2 phase ", name}, phase, 1);
        chk({"R9 clear ", name}, noise, 0);
      end
      if (k == 8)  chk({"R3 phase ", name}, phase, 8);
      if (k == 10) begin
        chk({"R7 phase ", name}, phase, ok ? 10 : 0);
        chk({"R6 noise ", name}, noise, nz);
      end
      if (k == 15) chk({"R8 early ", name}, start, 0);
      if (k == 16) begin
        chk({"R5 start ", name}, start, ok);
        chk({"R6 noise ", name}, noise, nz);
        chk({"R8 phase ", name}, phase, 0);
      end
      rx = (k < 16) ? pat[k+1] : 1'b1;
    end
    @(negedge clk);
    chk({"R8 width ", name}, start, 0);
    last_noise = nz;
  endtask

  task automatic glitch_after_abort();
    logic [26:0] s = 27'b0010101000_110_1110_1111111111;
    lead_ones();
    rx = s[26];
    for (int i = 0; i < 27; i++) begin
      take_tick();
      if (i == 9)  chk("R7 abort phase", phase, 0);
      if (i == 12) chk("R10 glitch ignored", phase, 0);
      if (i == 16) chk("R10 rearm phase", phase, 1);
      if (i == 26) chk("R7 second abort", phase, 0);
      if (start) chk("R7 no start", 1, 0);
      rx = (i < 26) ? s[25-i] : 1'b1;
    end
    chk("R7 noise after abort", noise, 0);
    last_noise = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 start", start, 0);
    chk("R1 noise", noise, 0);
    chk("R1 phase", phase, 0);
    rst_n = 1'b1;
    run_case("clean",      16'b0000_0000_0000_0000); // R5
    run_case("noise_a",    16'b0000_1000_0000_0000); // R6
    run_case("clean_after",16'b0000_0000_0000_0000); // R9
    run_case("noise_both", 16'b0010_0000_1000_0000); // R6
    run_case("noise_b",    16'b0000_0000_0100_0000); // R6
    run_case("abort_a",    16'b0010_0010_0000_0000); // R7
    run_case("abort_b",    16'b0000_0001_0100_0000); // R7
    run_case("ignored",    16'b0101_0100_0011_1111); // R4
    glitch_after_abort();                            // R10
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule